// File: doc/BRIEF.md
# Full-Map Coherence Directory Controller

This block sits beside shared memory in a small multiprocessor whose caches talk to memory over a point-to-point network rather than a snooped bus. For every block it tracks, it holds a presence vector with one bit per cache and a dirty flag. Caches send it requests for a readable copy or for write permission. It sends invalidate messages only to the caches whose presence bit is set, waits until each of them has acknowledged, and only then hands out write permission. This keeps memory consistent in a sequential order.

Requests are handled one at a time. A request is accepted in a cycle when `req_valid` is high and `req_ready` is high. While an invalidation round or a write-back is outstanding, `req_ready` stays low. Grants, invalidates and write-back requests are one-cycle pulses, registered, and appear in the cycle after the decision that causes them. A side lookup port exposes the stored state of any entry combinationally.

Top module: `fullmap_dir`

## Requirements
- R1: After reset every entry reads back with an all-zero presence vector and dirty clear, `req_ready` is 1, and no grant, invalidate or write-back pulse is asserted.
- R2: A read request (`req_write`=0) to a block that is not dirty sets the requester's presence bit, leaves dirty clear, and pulses `grant_valid` with `grant_write`=0 and `grant_dst` equal to the requester in the cycle after acceptance.
- R3: A write-permission request (`req_write`=1) pulses `inv_valid` for one cycle, in the cycle after acceptance, with bit i set exactly for each cache i other than the requester whose presence bit is set.
- R4: Write permission (`grant_write`=1) is granted in the cycle after the last outstanding acknowledgement arrives, and not before. The entry then holds dirty set and a presence vector with only the requester's bit set.
- R5: A write-permission request to a block with no other holder grants write permission in the cycle after acceptance, with no invalidate sent.
- R6: An acknowledgement bit in `ack_valid` from a cache that was not sent an invalidate in the current round has no effect.
- R7: While invalidate acknowledgements or a write-back are outstanding, `req_ready` is 0 and requests presented on the request port are not accepted.
- R8: Whenever an entry's dirty flag is set, exactly one of its presence bits is set.
- R9: A read request to a block that another cache holds dirty pulses `wb_req_valid` to that owner in the cycle after acceptance. When `wb_done` arrives with `wb_done_src` equal to the owner, the entry becomes clean with both the owner's and the requester's presence bits set, and the read grant follows in the next cycle. A `wb_done` from any other cache is ignored.
- R10: A read or write request from the cache that already owns a dirty block is granted in the cycle after acceptance, and the entry is left unchanged.
- R11: The acknowledgement counter is loaded with the number of invalidates sent, and it always equals the number of caches still owing an acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_write | input | 1 | 1 = write permission, 0 = read copy |
| req_src | input | SW | Requesting cache index |
| req_idx | input | IW | Directory entry index |
| inv_valid | output | N_CACHE | Invalidate pulse, bit i to cache i |
| ack_valid | input | N_CACHE | Invalidate acknowledgement, bit i from cache i |
| wb_req_valid | output | 1 | Write-back request pulse to the dirty owner |
| wb_req_dst | output | SW | Owner asked to write back |
| wb_done | input | 1 | Write-back data has reached memory |
| wb_done_src | input | SW | Cache reporting the write-back |
| grant_valid | output | 1 | Grant pulse |
| grant_write | output | 1 | 1 = write permission, 0 = read copy |
| grant_dst | output | SW | Cache receiving the grant |
| q_idx | input | IW | Lookup index |
| q_presence | output | N_CACHE | Presence vector of the looked-up entry |
| q_dirty | output | 1 | Dirty flag of the looked-up entry |

## Verification
The bench builds the directory with five caches and four entries. A cache count that is not a power of two exercises unused source codes and a counter that must reach four outstanding acknowledgements. With four entries, spoofed requests to neighbouring entries during a wait would show up in the lookup if they leaked through. Invalidations are acknowledged one at a time with gaps, all at once, and mixed with stray acknowledgements. Write-backs are answered late, and one of them is preceded by a response from the wrong cache.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_WB   = 2'd2
  } dir_state_e;
endpackage

// File: rtl/dir_ack_tracker.sv
// Tracks which invalidated caches still owe an acknowledgement, plus a count.
module dir_ack_tracker #(
  parameter int N_CACHE = 4,
  localparam int CW = $clog2(N_CACHE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [N_CACHE-1:0] load_mask,
  input  logic [N_CACHE-1:0] ack,
  output logic [CW-1:0]      count,
  output logic               last
);
  logic [N_CACHE-1:0] pend_q, pend_d, hit;
  logic [CW-1:0]      cnt_q, cnt_d, hit_n, load_n;
  logic               upd;

  always_comb begin
    hit    = ack & pend_q;
    hit_n  = '0;
    load_n = '0;
    for (int i = 0; i < N_CACHE; i++) begin
      hit_n  = hit_n + CW'(hit[i]);
      load_n = load_n + CW'(load_mask[i]);
    end
    last = (cnt_q != '0) && (hit_n == cnt_q);
    upd  = load || (|hit);
    if (load) begin
      pend_d = load_mask;
      cnt_d  = load_n;
    end else begin
      pend_d = pend_q & ~hit;
      cnt_d  = cnt_q - hit_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign count = cnt_q;

  // R11: the count always matches the outstanding set
  assert_count_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) == $countones(pend_q));
  // R11: never more acknowledgements accepted than owed
  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hit_n <= cnt_q);
endmodule

// File: rtl/dir_table.sv
// Directory storage: presence vector and dirty flag per entry, two read ports.
module dir_table #(
  parameter int N_CACHE = 4,
  parameter int N_ENTRY = 8,
  localparam int IW = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [N_CACHE-1:0] wr_pres,
  input  logic               wr_dirty,
  input  logic [IW-1:0]      rd_idx,
  output logic [N_CACHE-1:0] rd_pres,
  output logic               rd_dirty,
  input  logic [IW-1:0]      q_idx,
  output logic [N_CACHE-1:0] q_pres,
  output logic               q_dirty
);
  logic [N_CACHE-1:0] pres_q  [N_ENTRY];
  logic               dirty_q [N_ENTRY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENTRY; e++) begin
        pres_q[e]  <= '0;
        dirty_q[e] <= 1'b0;
      end
    end else if (wr_en) begin
      pres_q[wr_idx]  <= wr_pres;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  assign rd_pres  = pres_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign q_pres   = pres_q[q_idx];
  assign q_dirty  = dirty_q[q_idx];

  // R8: a dirty entry names exactly one holder
  for (genvar g = 0; g < N_ENTRY; g++) begin : g_inv
    assert_dirty_single_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q[g] |-> $countones(pres_q[g]) == 1);
  end
endmodule

// File: rtl/fullmap_dir.sv
// Full-map directory sequencer: one request in flight at a time.
module fullmap_dir
  import dir_pkg::*;
#(
  parameter int N_CACHE = 4,
  parameter int N_ENTRY = 8,
  localparam int SW = (N_CACHE > 1) ? $clog2(N_CACHE) : 1,
  localparam int IW = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1,
  localparam int CW = $clog2(N_CACHE + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [SW-1:0]      req_src,
  input  logic [IW-1:0]      req_idx,
  output logic [N_CACHE-1:0] inv_valid,
  input  logic [N_CACHE-1:0] ack_valid,
  output logic               wb_req_valid,
  output logic [SW-1:0]      wb_req_dst,
  input  logic               wb_done,
  input  logic [SW-1:0]      wb_done_src,
  output logic               grant_valid,
  output logic               grant_write,
  output logic [SW-1:0]      grant_dst,
  input  logic [IW-1:0]      q_idx,
  output logic [N_CACHE-1:0] q_presence,
  output logic               q_dirty
);
  dir_state_e         st_q, st_d;
  logic [SW-1:0]      sv_src_q, sv_src_d, own_q, own_d, own_enc;
  logic [IW-1:0]      sv_idx_q, sv_idx_d;
  logic               gv_q, gv_d, gw_q, gw_d, wbv_q, wbv_d;
  logic [SW-1:0]      gd_q, gd_d, wbd_q, wbd_d;
  logic [N_CACHE-1:0] inv_q, inv_d;

  logic [IW-1:0]      rd_idx;
  logic [N_CACHE-1:0] rd_pres, src_oh, sv_oh, others;
  logic               rd_dirty, accept;
  logic               wr_en, wr_dirty, trk_load, trk_last;
  logic [N_CACHE-1:0] wr_pres;
  logic [CW-1:0]      trk_cnt;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_idx    = req_ready ? req_idx : sv_idx_q;

  always_comb begin
    own_enc = '0;
    for (int i = 0; i < N_CACHE; i++) begin
      src_oh[i] = (req_src == SW'(i));
      sv_oh[i]  = (sv_src_q == SW'(i));
    end
    others = rd_pres & ~src_oh;
    for (int i = 0; i < N_CACHE; i++) begin
      if (others[i]) own_enc = SW'(i);
    end
  end

  dir_table #(.N_CACHE(N_CACHE), .N_ENTRY(N_ENTRY)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(sv_idx_d), .wr_pres(wr_pres), .wr_dirty(wr_dirty),
    .rd_idx(rd_idx), .rd_pres(rd_pres), .rd_dirty(rd_dirty),
    .q_idx(q_idx), .q_pres(q_presence), .q_dirty(q_dirty)
  );

  dir_ack_tracker #(.N_CACHE(N_CACHE)) u_acks (
    .clk(clk), .rst_n(rst_n),
    .load(trk_load), .load_mask(others), .ack(ack_valid),
    .count(trk_cnt), .last(trk_last)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    sv_src_d = sv_src_q;
    sv_idx_d = sv_idx_q;
    own_d    = own_q;
    gv_d     = 1'b0;
    gw_d     = 1'b0;
    gd_d     = gd_q;
    inv_d    = '0;
    wbv_d    = 1'b0;
    wbd_d    = wbd_q;
    wr_en    = 1'b0;
    wr_pres  = rd_pres;
    wr_dirty = rd_dirty;
    trk_load = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          sv_src_d = req_src;
          sv_idx_d = req_idx;
          if (req_write) begin
            if (others == '0) begin
              wr_en    = 1'b1;
              wr_pres  = src_oh;
              wr_dirty = 1'b1;
              gv_d     = 1'b1;
              gw_d     = 1'b1;
              gd_d     = req_src;
            end else begin
              inv_d    = others;
              trk_load = 1'b1;
              st_d     = ST_ACK;
            end
          end else if (rd_dirty && (others != '0)) begin
            own_d = own_enc;
            wbv_d = 1'b1;
            wbd_d = own_enc;
            st_d  = ST_WB;
          end else begin
            wr_en    = !rd_dirty;
            wr_pres  = rd_pres | src_oh;
            wr_dirty = rd_dirty;
            gv_d     = 1'b1;
            gd_d     = req_src;
          end
        end
      end
      ST_ACK: begin
        if (trk_last) begin
          wr_en    = 1'b1;
          wr_pres  = sv_oh;
          wr_dirty = 1'b1;
          gv_d     = 1'b1;
          gw_d     = 1'b1;
          gd_d     = sv_src_q;
          st_d     = ST_IDLE;
        end
      end
      ST_WB: begin
        if (wb_done && (wb_done_src == own_q)) begin
          wr_en    = 1'b1;
          wr_pres  = rd_pres | sv_oh;
          wr_dirty = 1'b0;
          gv_d     = 1'b1;
          gd_d     = sv_src_q;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sv_src_q <= '0;
      sv_idx_q <= '0;
      own_q    <= '0;
      gv_q     <= 1'b0;
      gw_q     <= 1'b0;
      gd_q     <= '0;
      inv_q    <= '0;
      wbv_q    <= 1'b0;
      wbd_q    <= '0;
    end else begin
      st_q  <= st_d;
      gv_q  <= gv_d;
      gw_q  <= gw_d;
      gd_q  <= gd_d;
      inv_q <= inv_d;
      wbv_q <= wbv_d;
      wbd_q <= wbd_d;
      if (accept) begin
        sv_src_q <= sv_src_d;
        sv_idx_q <= sv_idx_d;
        own_q    <= own_d;
      end
    end
  end

  assign inv_valid    = inv_q;
  assign wb_req_valid = wbv_q;
  assign wb_req_dst   = wbd_q;
  assign grant_valid  = gv_q;
  assign grant_write  = gw_q;
  assign grant_dst    = gd_q;

  // R3: invalidates reach only current holders, never the requester
  assert_inv_holders_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_q) |-> (((inv_q & ~rd_pres) == '0) && ((inv_q & sv_oh) == '0)));
  // R4: write permission never leaves while acknowledgements are owed
  assert_write_after_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gv_q && gw_q) |-> (trk_cnt == '0));
  // R7: an invalidation round closes the request port
  assert_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && (others != '0)) |=> (!req_ready && (inv_valid != '0)));
  // R9: a write-back is asked for only while the entry is dirty
  assert_wb_dirty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wbv_q |-> rd_dirty);
endmodule

// File: tb/test_fullmap_dir.sv
module test_fullmap_dir;
  localparam int NC = 5;
  localparam int NE = 4;
  localparam int SW = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, wb_done;
  logic [SW-1:0] req_src, wb_done_src;
  logic [IW-1:0] req_idx, q_idx;
  logic [NC-1:0] ack_valid;
  logic req_ready, wb_req_valid, grant_valid, grant_write, q_dirty;
  logic [NC-1:0] inv_valid, q_presence;
  logic [SW-1:0] wb_req_dst, grant_dst;

  int n_cmp = 0;
  int n_bad = 0;

  logic [NC-1:0] mpres [NE];
  bit            mdirty [NE];

  bit e_rdy, e_gv, e_gw, e_wb;
  int e_inv, e_gd, e_wbd;

  always #2.5ns clk = ~clk;

  fullmap_dir #(.N_CACHE(NC), .N_ENTRY(NE)) i_fullmap_dir (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_src(req_src), .req_idx(req_idx),
    .inv_valid(inv_valid), .ack_valid(ack_valid),
    .wb_req_valid(wb_req_valid), .wb_req_dst(wb_req_dst),
    .wb_done(wb_done), .wb_done_src(wb_done_src),
    .grant_valid(grant_valid), .grant_write(grant_write), .grant_dst(grant_dst),
    .q_idx(q_idx), .q_presence(q_presence), .q_dirty(q_dirty)
  );

  task automatic cmp(string tag, string nm, int act, int exp_v);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp_v);
    end
  endtask

  task automatic expect_out(bit rdy, int inv, bit gv, bit gw, int gd, bit wb, int wbd);
    e_rdy = rdy; e_inv = inv; e_gv = gv; e_gw = gw; e_gd = gd; e_wb = wb; e_wbd = wbd;
  endtask

  task automatic sample(string tag);
    cmp(tag, "req_ready", int'(req_ready), int'(e_rdy));
    cmp(tag, "inv_valid", int'(inv_valid), e_inv);
    cmp(tag, "grant_valid", int'(grant_valid), int'(e_gv));
    if (e_gv) begin
      cmp(tag, "grant_write", int'(grant_write), int'(e_gw));
      cmp(tag, "grant_dst", int'(grant_dst), e_gd);
    end
    cmp(tag, "wb_req_valid", int'(wb_req_valid), int'(e_wb));
    if (e_wb) cmp(tag, "wb_req_dst", int'(wb_req_dst), e_wbd);
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    @(negedge clk);
    sample(tag);
  endtask

  task automatic check_dir(string tag);
    for (int e = 0; e < NE; e++) begin
      q_idx = IW'(e);
      #0.2ns;
      cmp(tag, "q_presence", int'(q_presence), int'(mpres[e]));
      cmp(tag, "q_dirty", int'(q_dirty), int'(mdirty[e]));
    end
  endtask

  task automatic rd(int src, int idx, int dly, bit bad);
    logic [NC-1:0] sb, oth;
    int own;
    sb  = NC'(1) << src;
    oth = mpres[idx] & ~sb;
    req_valid = 1'b1; req_write = 1'b0; req_src = SW'(src); req_idx = IW'(idx);
    if (mdirty[idx] && oth != '0) begin
      own = 0;
      for (int i = 0; i < NC; i++) if (oth[i]) own = i;
      expect_out(0, 0, 0, 0, 0, 1, own);
      tick("R9");
      req_src = SW'((src + 1) % NC);      // R7: spoofed request must wait
      req_idx = IW'((idx + 1) % NE);
      expect_out(0, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < dly; k++) begin
        if (bad && k == 0) begin
          wb_done = 1'b1; wb_done_src = SW'((own + 1) % NC);
        end
        tick((bad && k == 0) ? "R9" : "R7");
        wb_done = 1'b0;
      end
      req_valid = 1'b0;
      wb_done = 1'b1; wb_done_src = SW'(own);
      expect_out(1, 0, 1, 0, src, 0, 0);
      tick("R9");
      wb_done = 1'b0;
      mpres[idx] = oth | sb;
      mdirty[idx] = 1'b0;
      expect_out(1, 0, 0, 0, 0, 0, 0);
      check_dir("R9");
    end else begin
      expect_out(1, 0, 1, 0, src, 0, 0);
      tick(mdirty[idx] ? "R10" : "R2");
      req_valid = 1'b0;
      if (!mdirty[idx]) mpres[idx] = mpres[idx] | sb;
      expect_out(1, 0, 0, 0, 0, 0, 0);
      check_dir(mdirty[idx] ? "R10" : "R2");
    end
  endtask

  task automatic wr(int src, int idx, int gap, bit stray, bit bulk);
    logic [NC-1:0] sb, oth, rem;
    sb  = NC'(1) << src;
    oth = mpres[idx] & ~sb;
    req_valid = 1'b1; req_write = 1'b1; req_src = SW'(src); req_idx = IW'(idx);
    if (oth == '0) begin
      expect_out(1, 0, 1, 1, src, 0, 0);
      tick(mdirty[idx] ? "R10" : "R5");
      req_valid = 1'b0;
    end else begin
      expect_out(0, int'(oth), 0, 0, 0, 0, 0);
      tick("R3");
      req_idx = IW'((idx + 1) % NE);      // R7: spoofed request must wait
      expect_out(0, 0, 0, 0, 0, 0, 0);
      if (stray) begin
        ack_valid = ~oth;
        tick("R6");
        ack_valid = '0;
      end
      if (bulk) begin
        req_valid = 1'b0;
        ack_valid = oth;
        expect_out(1, 0, 1, 1, src, 0, 0);
        tick("R4");
        ack_valid = '0;
      end else begin
        rem = oth;
        for (int i = 0; i < NC; i++) begin
          if (oth[i]) begin
            for (int g = 0; g < gap; g++) tick("R7");
            rem[i] = 1'b0;
            ack_valid = NC'(1) << i;
            if (rem == '0) begin
              req_valid = 1'b0;
              expect_out(1, 0, 1, 1, src, 0, 0);
            end
            tick("R4");
            ack_valid = '0;
          end
        end
      end
    end
    mpres[idx]  = sb;
    mdirty[idx] = 1'b1;
    expect_out(1, 0, 0, 0, 0, 0, 0);
    check_dir("R4");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1000000ns;
    n_bad++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_src = '0; req_idx = '0;
    ack_valid = '0; wb_done = 1'b0; wb_done_src = '0; q_idx = '0;
    for (int e = 0; e < NE; e++) begin
      mpres[e] = '0;
      mdirty[e] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    expect_out(1, 0, 0, 0, 0, 0, 0);
    sample("R1");
    check_dir("R1");

    // sharers build up on entry 1, then one writer invalidates them
    rd(0, 1, 0, 0);
    rd(2, 1, 0, 0);
    rd(3, 1, 0, 0);
    rd(4, 1, 0, 0);
    wr(2, 1, 1, 1, 0);          // R3 R4 R6 R7 R11, staggered acks
    // empty entry, owner repeats
    wr(1, 2, 0, 0, 0);          // R5
    rd(1, 2, 0, 0);             // R10
    wr(1, 2, 0, 0, 0);          // R10
    // dirty read by another cache with a wrong write-back source first
    rd(3, 2, 2, 1);             // R9
    rd(0, 2, 0, 0);             // R2
    wr(4, 2, 0, 1, 1);          // R4 R6, acks together
    wr(0, 2, 2, 0, 0);          // dirty owner invalidated
    rd(2, 2, 0, 0);             // R9 no delay
    // four sharers outstanding at once
    for (int c = 0; c < NC; c++) rd(c, 3, 0, 0);
    wr(0, 3, 0, 0, 1);          // R11 full count
    wr(3, 3, 0, 1, 0);
    // idle stray responses leave everything alone
    ack_valid = '1; wb_done = 1'b1; wb_done_src = SW'(3);
    tick("R6");
    ack_valid = '0; wb_done = 1'b0;
    check_dir("R6");
    finish_run();
  end
endmodule